// File: doc/BRIEF.md
# Gate-Driver Feedback Fault Checker

This block watches the optical feedback returned by a set of power-switch gate drivers and checks it against the gate command that the chip itself sends to those drivers. Every time a channel's command toggles, in either direction, its driver must answer with a short dark pulse on its feedback fibre. The block raises a fault for that channel if no pulse arrives within a window. It also raises a fault if the pulse stays dark for too long, which signals a short circuit at the switch.

Feedback inputs are asynchronous. Each one is synchronised and then glitch-filtered before it is used. Command inputs come from the same clock domain. Faults are latched per channel and also ORed onto one error line for the supervising microcontroller. Only a dedicated clear input removes them. Checking stays disabled for a fixed number of cycles after reset release, so that start-up transients cannot latch faults. Without a command edge, the feedback line is never examined, so noise on an idle link raises nothing.

Top module: `gdfb_checker`

## Requirements
- R1: During and right after synchronous reset, `flt_o` is all zeros and `err_o` is 0.
- R2: After a command edge, rising or falling, a dark pulse (`fb_i` = 0) that starts well inside `ACK_WIN` cycles and ends well before `SC_LIMIT` cycles raises no fault.
- R3: If no dark pulse is seen within `ACK_WIN` cycles of a command edge, that channel's bit in `flt_o` is set.
- R4: A dark pulse that follows a command edge and lasts `SC_LIMIT` cycles or more sets that channel's bit in `flt_o`.
- R5: While a channel's command is unchanged, its feedback line has no effect, even when it is dark for longer than `SC_LIMIT` cycles.
- R6: A dark dip shorter than `FILT_LEN` cycles is not taken as an acknowledgement, so an edge answered only by such dips faults as unanswered.
- R7: A set fault bit stays set until `flt_clr_i` is asserted for a cycle. It reads 0 on the following cycle unless a new fault is detected in that same cycle, in which case the new fault wins.
- R8: `err_o` equals the OR of all `flt_o` bits in every cycle.
- R9: Command edges during the first `ARM_DLY` cycles after reset release are ignored and raise no fault, whatever the feedback does.
- R10: Channels are independent: a fault on one channel sets only that channel's bit.
- R11: A further command edge while the block is waiting for the acknowledgement restarts the `ACK_WIN` window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | NCH | Gate command sent to each driver (same clock domain) |
| fb_i | input | NCH | Asynchronous feedback per channel, 1 = light, 0 = dark pulse |
| flt_clr_i | input | 1 | Clears all latched faults |
| flt_o | output | NCH | Latched per-channel fault flags |
| err_o | output | 1 | OR of all latched faults |

## Verification
A checker that stays stuck in its waiting or measuring state shows up as a fault bit. That bit appears one `ACK_WIN` or `SC_LIMIT` period after the edge that started the check. A lost edge shows up as a missing fault, and it is visible a few cycles after the expected deadline. Because of this, every check is timed with a margin on both sides of the window bound it exercises. A filter or synchroniser that lets too much through only shows at the ports when an edge is answered by glitches alone. So the bench drives exactly that case, and a wrongly cleared latch is caught by reading `flt_o` long after the fault.

// File: rtl/gdfb_pkg.sv
package gdfb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PULSE = 2'd2
  } gdfb_state_e;
endpackage

// File: rtl/gdfb_sync.sv
module gdfb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {STAGES{RST_VAL}};
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/gdfb_filt.sv
module gdfb_filt #(
  parameter int   LEN     = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_i,
  output logic out_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      out_q <= RST_VAL;
    end else if (in_i == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      out_q <= in_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign out_o = out_q;

  // R6
  filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (out_q != $past(out_q)) |-> ($past(in_i) == out_q));
endmodule

// File: rtl/gdfb_chan.sv
module gdfb_chan
  import gdfb_pkg::*;
#(
  parameter int ACK_WIN  = 200,
  parameter int SC_LIMIT = 375
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic cmd_i,
  input  logic fb_i,
  input  logic clr_i,
  output logic flt_o,
  output logic flt_d_o
);
  localparam int MAXW = (ACK_WIN > SC_LIMIT) ? ACK_WIN : SC_LIMIT;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] ACK_LAST = CW'(ACK_WIN - 1);
  localparam logic [CW-1:0] SC_LAST  = CW'(SC_LIMIT - 1);

  gdfb_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cmd_q;
  logic          edge_w;
  logic          det;
  logic          flt_q, flt_d;

  assign edge_w = cmd_i ^ cmd_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    det   = 1'b0;
    if (!arm_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (edge_w) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
          end
        end
        ST_WAIT: begin
          if (!fb_i) begin
            st_d  = ST_PULSE;
            cnt_d = CW'(1);
          end else if (edge_w) begin
            cnt_d = '0;
          end else if (cnt_q == ACK_LAST) begin
            det   = 1'b1;
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PULSE: begin
          if (fb_i) begin
            st_d  = edge_w ? ST_WAIT : ST_IDLE;
            cnt_d = '0;
          end else if (cnt_q >= SC_LAST) begin
            det   = 1'b1;
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_comb begin
    if (det)        flt_d = 1'b1;
    else if (clr_i) flt_d = 1'b0;
    else            flt_d = flt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cmd_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cmd_q <= cmd_i;
      flt_q <= flt_d;
    end
  end

  assign flt_o   = flt_q;
  assign flt_d_o = flt_d;

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_q && !clr_i) |=> flt_q);

  // R9
  arm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !arm_i |=> (st_q == ST_IDLE));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PULSE) |-> (cnt_q < CW'(SC_LIMIT)));

  // R3
  wait_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> (cnt_q < CW'(ACK_WIN)));

  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !edge_w) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/gdfb_checker.sv
module gdfb_checker #(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int ACK_WIN     = 200,
  parameter int SC_LIMIT    = 375,
  parameter int ARM_DLY     = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cmd_i,
  input  logic [NCH-1:0] fb_i,
  input  logic           flt_clr_i,
  output logic [NCH-1:0] flt_o,
  output logic           err_o
);
  localparam int AW = $clog2(ARM_DLY + 1);
  localparam logic [AW-1:0] ARM_LAST = AW'(ARM_DLY - 1);

  logic [AW-1:0]  arm_cnt_q;
  logic           armed_q;
  logic [NCH-1:0] fb_s, fb_f, flt_w, flt_d_w;
  logic           err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cnt_q <= '0;
      armed_q   <= 1'b0;
    end else if (!armed_q) begin
      if (arm_cnt_q == ARM_LAST) armed_q <= 1'b1;
      else                       arm_cnt_q <= arm_cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    gdfb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d_i(fb_i[g]), .q_o(fb_s[g])
    );
    gdfb_filt #(.LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst(rst), .in_i(fb_s[g]), .out_o(fb_f[g])
    );
    gdfb_chan #(.ACK_WIN(ACK_WIN), .SC_LIMIT(SC_LIMIT)) u_chan (
      .clk(clk), .rst(rst), .arm_i(armed_q), .cmd_i(cmd_i[g]),
      .fb_i(fb_f[g]), .clr_i(flt_clr_i), .flt_o(flt_w[g]),
      .flt_d_o(flt_d_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= |flt_d_w;
  end

  assign flt_o = flt_w;
  assign err_o = err_q;

  // R8
  err_or_chk: assert property (@(posedge clk) disable iff (rst)
    err_q == (|flt_w));

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (flt_w == '0 && !err_q));
endmodule

// File: tb/gdfb_checker_bench.sv
`timescale 1ns/1ps
module gdfb_checker_bench;
  localparam int NCH      = 4;
  localparam int FILT_LEN = 4;
  localparam int ACK_WIN  = 200;
  localparam int SC_LIMIT = 375;
  localparam int ARM_DLY  = 64;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] cmd = '0;
  logic [NCH-1:0] fb  = '1;
  logic           clr = 1'b0;
  logic [NCH-1:0] flt_o;
  logic           err_o;
  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  gdfb_checker #(.NCH(NCH), .FILT_LEN(FILT_LEN), .ACK_WIN(ACK_WIN),
                 .SC_LIMIT(SC_LIMIT), .ARM_DLY(ARM_DLY)) u_gdfb_checker (
    .clk(clk), .rst(rst), .cmd_i(cmd), .fb_i(fb), .flt_clr_i(clr),
    .flt_o(flt_o), .err_o(err_o)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NCH-1:0] exp);
    vectors++;
    if (flt_o !== exp) begin
      miscompares++;
      $display("FAIL %s flt_o actual=%b expected=%b", req, flt_o, exp);
    end
    vectors++;
    if (err_o !== (|exp)) begin
      miscompares++;
      $display("FAIL %s/R8 err_o actual=%b expected=%b", req, err_o, |exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    wait_cyc(2);
  endtask

  task automatic do_reset();
    rst = 1'b1; fb = '1; clr = 1'b0;
    wait_cyc(4);
    check("R1 in reset", '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic ack(input int ch, input int dly, input int len);
    wait_cyc(dly);
    fb[ch] = 1'b0;
    wait_cyc(len);
    fb[ch] = 1'b1;
  endtask

  task automatic t_arm();
    do_reset();
    wait_cyc(5);
    cmd[1] = ~cmd[1];
    wait_cyc(ACK_WIN + 60);
    check("R9 edge before arming", '0);
  endtask

  task automatic t_good();
    clear_all();
    cmd[0] = ~cmd[0];
    ack(0, 40, 100);
    wait_cyc(ACK_WIN + 60);
    check("R2 rising edge acked", '0);
    @(negedge clk); cmd[0] = ~cmd[0];
    ack(0, 30, 150);
    wait_cyc(ACK_WIN + 60);
    check("R2 falling edge acked", '0);
  endtask

  task automatic t_missing();
    clear_all();
    cmd[2] = ~cmd[2];
    wait_cyc(ACK_WIN - 20);
    check("R3 before window end", '0);
    wait_cyc(40);
    check("R3/R10 missing ack on ch2", 4'b0100);
    wait_cyc(500);
    check("R7 fault held", 4'b0100);
    clear_all();
    check("R7 cleared", '0);
  endtask

  task automatic t_short();
    clear_all();
    cmd[3] = ~cmd[3];
    wait_cyc(20);
    fb[3] = 1'b0;
    wait_cyc(SC_LIMIT - 20);
    check("R4 pulse under limit", '0);
    wait_cyc(40);
    check("R4/R10 over-long pulse on ch3", 4'b1000);
    fb[3] = 1'b1;
    wait_cyc(20);
    clear_all();
    check("R7 cleared after short", '0);
  endtask

  task automatic t_quiet();
    clear_all();
    fb = '0;
    wait_cyc(SC_LIMIT * 3);
    fb = '1;
    wait_cyc(30);
    fb[1] = 1'b0; wait_cyc(10); fb[1] = 1'b1;
    wait_cyc(ACK_WIN + 40);
    check("R5 feedback without edge", '0);
  endtask

  task automatic t_glitch();
    clear_all();
    cmd[0] = ~cmd[0];
    for (int k = 0; k < 6; k++) begin
      wait_cyc(25);
      fb[0] = 1'b0;
      wait_cyc(FILT_LEN - 2);
      fb[0] = 1'b1;
    end
    wait_cyc(ACK_WIN);
    check("R6 glitches not an ack", 4'b0001);
    clear_all();
  endtask

  task automatic t_restart();
    clear_all();
    cmd[1] = ~cmd[1];
    wait_cyc(ACK_WIN - 50);
    cmd[1] = ~cmd[1];
    wait_cyc(ACK_WIN - 50);
    check("R11 window restarted", '0);
    ack(1, 0, 80);
    wait_cyc(ACK_WIN + 40);
    check("R11 late ack accepted", '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_arm();
    t_good();
    t_missing();
    t_short();
    t_quiet();
    t_glitch();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule